// File: doc/BRIEF.md
# Compare-and-Skip Execution Unit

This unit executes the two byte-wide compare-and-skip operations of a small 8-bit accumulator processor. It takes one instruction word per instruction cycle over a valid/ready handshake and decodes it. It then forms a 12-bit data-memory address from the instruction's file field, the bank register, the extended-mode flag and an index base. In phase Q2 it reads the addressed byte, and in phase Q3 it compares that byte with the working register as unsigned numbers. When the skip condition holds, it squashes the already-fetched next instruction into a no-op. The squash lasts one instruction cycle, or two when the squashed instruction is two words long. The compare never produces a status flag: the subtraction only decides the skip.

Each instruction cycle has four phases, Q1 to Q4, with one clock per phase. The `q_phase` output shows the current phase, encoded 0 for Q1 through 3 for Q4. The handshake rules are as follows. `ins_ready` can only be high in Q1, and it is held low for the whole of a squash window. An instruction is taken on a clock edge where `ins_valid` and `ins_ready` are both high. A source that meets a low `ins_ready` must hold `ins_valid` and `ins_word` until the transfer completes. Register values such as `wreg`, `bank_sel`, `ext_mode` and `index_base` are captured at acceptance. `next_two_word` is sampled at the end of Q4 of the compare instruction.

Top module: `cs_skip_unit`

## Requirements
- R1: Bits 15..9 equal to 0110010 select the greater-than variant, and bits 15..9 equal to 0110000 select the less-than variant. In both, bit 8 is the access bit and bits 7..0 are the file field f.
- R2: With the access bit at 1, the read address is {bank_sel, f}.
- R3: With the access bit at 0 and no indexed addressing, f from 0x00 to 0x5F reads {0x0, f}, and f from 0x60 to 0xFF reads {0xF, f}.
- R4: With the access bit at 0, `ext_mode` at 1 and f at or below 0x5F, the read address is index_base + f, taken modulo 4096.
- R5: The greater-than variant skips only when the memory byte is strictly above `wreg` as unsigned numbers. Equal values do not skip.
- R6: The less-than variant skips only when the memory byte is strictly below `wreg` as unsigned numbers. Equal values do not skip.
- R7: `q_phase` steps 0,1,2,3 and repeats. `ins_ready` is high only when `q_phase` is 0. `rd_req` is high exactly in the Q2 phase that follows acceptance of a compare instruction. `busy` is high in Q2 to Q4 of that instruction.
- R8: A taken skip holds `squash` and `busy` high from the next Q1 for 4 clocks. When `next_two_word` is 1, they stay high for 8 clocks.
- R9: When the skip is not taken, `squash` stays low and `ins_ready` is high at the next Q1.
- R10: Any other opcode is accepted but produces no `rd_req`, no `busy` and no `squash`.
- R11: While `squash` is high, `ins_ready` is low, and an offered instruction is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per Q phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Unit takes a word this clock (Q1, no squash) |
| ins_word | input | 16 | Instruction word |
| wreg | input | 8 | Working register value |
| bank_sel | input | 4 | Bank register for access bit 1 |
| ext_mode | input | 1 | Extended addressing enabled |
| index_base | input | 12 | Index register for literal-offset addressing |
| next_two_word | input | 1 | The fetched next instruction is two words |
| rd_req | output | 1 | Data-memory read strobe (Q2) |
| rd_addr | output | 12 | Data-memory read address |
| rd_data | input | 8 | Data-memory byte, valid while rd_req is high |
| q_phase | output | 2 | Current phase, 0 to 3 for Q1 to Q4 |
| squash | output | 1 | Current fetched instruction runs as a no-op |
| busy | output | 1 | Unit occupied by a compare or a squash |

## Verification
The end of a squash window and the next instruction handshake fall on the same Q1 boundary. In that boundary `ins_ready` must rise at the very edge where `squash` drops. The bench holds `ins_valid` high with an unrelated word throughout every squash. It checks that `ins_ready` stays low in each squashed Q1, then checks that the next instruction is taken in the first free Q1 without losing a cycle. Skips with one-word and two-word successors, and equal-value compares that must not skip, are mixed with random address modes so that this boundary is reached from every path.

// File: rtl/cs_skip_pkg.sv
package cs_skip_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CPGT = 2'd1,
    OP_CPLT = 2'd2
  } cs_op_e;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } cs_phase_e;

  localparam logic [6:0] OPC_CPGT = 7'b0110010;
  localparam logic [6:0] OPC_CPLT = 7'b0110000;

  function automatic cs_op_e cs_classify(input logic [15:0] word);
    if (word[15:9] == OPC_CPGT)      return OP_CPGT;
    else if (word[15:9] == OPC_CPLT) return OP_CPLT;
    else                             return OP_NONE;
  endfunction

endpackage

// File: rtl/cs_decode.sv
module cs_decode
  import cs_skip_pkg::*;
#(
  parameter int F_W = 8
) (
  input  logic [15:0]    ins_word,
  output cs_op_e         op,
  output logic           acc_bit,
  output logic [F_W-1:0] f_field
);
  always_comb begin
    op      = cs_classify(ins_word);
    acc_bit = ins_word[F_W];
    f_field = ins_word[F_W-1:0];
  end
endmodule

// File: rtl/cs_addr_gen.sv
module cs_addr_gen #(
  parameter int F_W       = 8,
  parameter int BANK_W    = 4,
  parameter int IDX_LIMIT = 8'h5F,
  localparam int ADDR_W   = BANK_W + F_W
) (
  input  logic              acc_bit,
  input  logic [F_W-1:0]    f_field,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ext_mode,
  input  logic [ADDR_W-1:0] index_base,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [BANK_W-1:0] LOW_BANK  = '0;
  localparam logic [BANK_W-1:0] HIGH_BANK = '1;
  localparam logic [F_W-1:0]    LIMIT     = F_W'(IDX_LIMIT);

  logic low_half;
  logic [ADDR_W-1:0] idx_sum;

  always_comb begin
    low_half = (f_field <= LIMIT);
    idx_sum  = index_base + {{BANK_W{1'b0}}, f_field};
    if (acc_bit)
      addr = {bank_sel, f_field};
    else if (ext_mode && low_half)
      addr = idx_sum;
    else if (low_half)
      addr = {LOW_BANK, f_field};
    else
      addr = {HIGH_BANK, f_field};
  end
endmodule

// File: rtl/cs_compare.sv
module cs_compare
  import cs_skip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  cs_op_e            op,
  input  logic [DATA_W-1:0] mem_byte,
  input  logic [DATA_W-1:0] wval,
  output logic              skip
);
  logic [DATA_W:0] diff;
  logic borrow, zero;

  always_comb begin
    diff   = {1'b0, mem_byte} - {1'b0, wval};
    borrow = diff[DATA_W];
    zero   = (diff[DATA_W-1:0] == '0);
    unique case (op)
      OP_CPGT: skip = !borrow && !zero;
      OP_CPLT: skip = borrow;
      default: skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
  import cs_skip_pkg::*;
#(
  parameter int SHORT_SQ = 1,
  parameter int LONG_SQ  = 2,
  localparam int CNT_W   = $clog2(LONG_SQ + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      take_cmp,
  input  logic      skip,
  input  logic      two_word,
  output cs_phase_e phase,
  output logic      active,
  output logic      squash
);
  logic [CNT_W-1:0] sq_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_Q1;
      active <= 1'b0;
      sq_cnt <= '0;
    end else begin
      phase <= cs_phase_e'(phase + 2'd1);
      if (phase == PH_Q1 && take)
        active <= take_cmp;
      else if (phase == PH_Q4)
        active <= 1'b0;
      if (phase == PH_Q4) begin
        if (active)
          sq_cnt <= skip ? (two_word ? CNT_W'(LONG_SQ) : CNT_W'(SHORT_SQ)) : '0;
        else if (sq_cnt != '0)
          sq_cnt <= sq_cnt - 1'b1;
      end
    end
  end

  assign squash = (sq_cnt != '0);
endmodule

// File: rtl/cs_skip_unit.sv
module cs_skip_unit
  import cs_skip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_valid,
  output logic                     ins_ready,
  input  logic [15:0]              ins_word,
  input  logic [DATA_W-1:0]        wreg,
  input  logic [BANK_W-1:0]        bank_sel,
  input  logic                     ext_mode,
  input  logic [BANK_W+DATA_W-1:0] index_base,
  input  logic                     next_two_word,
  output logic                     rd_req,
  output logic [BANK_W+DATA_W-1:0] rd_addr,
  input  logic [DATA_W-1:0]        rd_data,
  output logic [1:0]               q_phase,
  output logic                     squash,
  output logic                     busy
);
  localparam int ADDR_W = BANK_W + DATA_W;

  cs_op_e            dec_op, op_q;
  logic              dec_acc;
  logic [DATA_W-1:0] dec_f;
  logic [ADDR_W-1:0] dec_addr, addr_q;
  logic [DATA_W-1:0] w_q, mem_q;
  cs_phase_e         phase;
  logic              active, skip, take;

  cs_decode #(.F_W(DATA_W)) u_dec (
    .ins_word(ins_word), .op(dec_op), .acc_bit(dec_acc), .f_field(dec_f)
  );

  cs_addr_gen #(.F_W(DATA_W), .BANK_W(BANK_W)) u_addr (
    .acc_bit(dec_acc), .f_field(dec_f), .bank_sel(bank_sel),
    .ext_mode(ext_mode), .index_base(index_base), .addr(dec_addr)
  );

  assign ins_ready = (phase == PH_Q1) && !squash;
  assign take      = ins_valid && ins_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      w_q    <= '0;
      mem_q  <= '0;
    end else begin
      if (take) begin
        op_q   <= dec_op;
        addr_q <= dec_addr;
        w_q    <= wreg;
      end
      if (rd_req)
        mem_q <= rd_data;
    end
  end

  cs_compare #(.DATA_W(DATA_W)) u_cmp (
    .op(op_q), .mem_byte(mem_q), .wval(w_q), .skip(skip)
  );

  cs_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .take_cmp(dec_op != OP_NONE),
    .skip(skip), .two_word(next_two_word),
    .phase(phase), .active(active), .squash(squash)
  );

  assign rd_req  = active && (phase == PH_Q2);
  assign rd_addr = addr_q;
  assign q_phase = phase;
  assign busy    = active || squash;
endmodule

// File: rtl/cs_skip_unit_chk.sv
module cs_skip_unit_chk
  import cs_skip_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ins_valid,
  input logic        ins_ready,
  input logic [15:0] ins_word,
  input logic        rd_req,
  input logic [1:0]  q_phase,
  input logic        squash,
  input logic        busy
);
  // R7
  ready_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> q_phase == 2'd0);
  // R7
  read_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (q_phase == 2'd1 && busy));
  // R10
  other_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && cs_classify(ins_word) == OP_NONE) |=> !rd_req);
  // R8
  squash_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(squash) |-> q_phase == 2'd0);
  // R8
  squash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && q_phase != 2'd3) |=> squash);
  // R11
  squash_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (!ins_ready && busy));
endmodule

bind cs_skip_unit cs_skip_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_word(ins_word), .rd_req(rd_req), .q_phase(q_phase),
  .squash(squash), .busy(busy)
);

// File: tb/cs_skip_unit_test.sv
module cs_skip_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [15:0] ins_word = 16'h0;
  logic [7:0]  wreg = 8'h0;
  logic [3:0]  bank_sel = 4'h0;
  logic        ext_mode = 1'b0;
  logic [11:0] index_base = 12'h0;
  logic        next_two_word = 1'b0;
  logic        rd_req;
  logic [11:0] rd_addr;
  logic [7:0]  rd_data;
  logic [1:0]  q_phase;
  logic        squash, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_val(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction
  assign rd_data = mem_val(rd_addr);

  cs_skip_unit uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .wreg(wreg), .bank_sel(bank_sel), .ext_mode(ext_mode),
    .index_base(index_base), .next_two_word(next_two_word), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .q_phase(q_phase),
    .squash(squash), .busy(busy)
  );

  // 1 = greater, 2 = less, 0 = other (R1)
  function automatic int exp_kind(input logic [15:0] w);
    if (w[15:9] == 7'b0110010) return 1;
    if (w[15:9] == 7'b0110000) return 2;
    return 0;
  endfunction

  function automatic logic [11:0] exp_addr(input logic [15:0] w, input logic [3:0] b,
                                           input logic e, input logic [11:0] ix);
    if (w[8]) return {b, w[7:0]};
    if (e && w[7:0] <= 8'h5F) return ix + {4'h0, w[7:0]};
    if (w[7:0] <= 8'h5F) return {4'h0, w[7:0]};
    return {4'hF, w[7:0]};
  endfunction

  function automatic string addr_tag(input logic [15:0] w, input logic e);
    if (w[8]) return "R2";
    if (e && w[7:0] <= 8'h5F) return "R4";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_ins(input logic [15:0] w, input logic [7:0] wv, input logic [3:0] b,
                         input logic e, input logic [11:0] ix, input logic two);
    int guard = 0;
    int kind = exp_kind(w);
    logic [11:0] ea = exp_addr(w, b, e, ix);
    bit sk;
    int n;
    while (!(ins_ready && q_phase == 2'd0) && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    ins_word = w; wreg = wv; bank_sel = b; ext_mode = e; index_base = ix;
    next_two_word = two; ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    chk(rd_req == (kind != 0), kind != 0 ? "R7" : "R10", rd_req, kind != 0);
    chk(busy == (kind != 0), kind != 0 ? "R7" : "R10", busy, kind != 0);
    if (kind != 0) chk(rd_addr == ea, addr_tag(w, e), rd_addr, ea);
    sk = (kind == 1 && mem_val(ea) > wv) || (kind == 2 && mem_val(ea) < wv);
    n = sk ? (two ? 2 : 1) : 0;
    repeat (3) @(negedge clk);
    chk(q_phase == 2'd0, "R7", q_phase, 0);
    if (kind == 1) chk(squash == sk, "R5", squash, sk);
    else if (kind == 2) chk(squash == sk, "R6", squash, sk);
    else chk(squash == 1'b0, "R10", squash, 0);
    for (int c = 0; c < n; c++) begin
      for (int p = 0; p < 4; p++) begin
        ins_valid = 1'b1; ins_word = 16'hFFFF;
        chk(squash && busy, "R8", squash, 1);
        if (p == 0) chk(ins_ready == 1'b0, "R11", ins_ready, 0);
        @(negedge clk);
      end
    end
    ins_valid = 1'b0;
    chk(!squash && ins_ready && q_phase == 2'd0, sk ? "R8" : "R9",
        {squash, ins_ready, q_phase}, 4'b0100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(q_phase == 2'd0 && !squash && !busy && !rd_req && ins_ready, "R7",
        {q_phase, squash, busy, rd_req, ins_ready}, 1);
    // R5: greater, equal, smaller with bank addressing (R2)
    run_ins(16'h6510, 8'h00, 4'h3, 1'b0, 12'h0, 1'b0);
    run_ins(16'h6510, mem_val(12'h310), 4'h3, 1'b0, 12'h0, 1'b0);
    run_ins(16'h6510, 8'hFF, 4'h3, 1'b0, 12'h0, 1'b0);
    // R6: less, equal, with access bank boundary (R3)
    run_ins(16'h605F, 8'hFF, 4'h0, 1'b0, 12'h0, 1'b0);
    run_ins(16'h6060, mem_val(12'hF60), 4'h0, 1'b0, 12'h0, 1'b0);
    run_ins(16'h6060, 8'h00, 4'h0, 1'b0, 12'h0, 1'b0);
    // R4: indexed, wrap, and f above limit falls back to access bank
    run_ins(16'h6420, 8'h00, 4'h0, 1'b1, 12'hFF0, 1'b0);
    run_ins(16'h645F, 8'h00, 4'h0, 1'b1, 12'h123, 1'b1);
    run_ins(16'h6480, 8'hFF, 4'h0, 1'b1, 12'h123, 1'b1);
    // R8: two-word squash
    run_ins(16'h6420, 8'h00, 4'h0, 1'b0, 12'h0, 1'b1);
    // R10: unrelated opcodes
    run_ins(16'h6210, 8'h00, 4'h0, 1'b0, 12'h0, 1'b1);
    run_ins(16'h0000, 8'h00, 4'h0, 1'b0, 12'h0, 1'b0);
    run_ins(16'h6610, 8'h00, 4'h0, 1'b0, 12'h0, 1'b0);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      logic [7:0]  wv;
      logic [3:0]  b  = 4'($urandom);
      logic        e  = 1'($urandom);
      logic [11:0] ix = 12'($urandom);
      int sel = int'($urandom % 4);
      w = 16'($urandom);
      if (sel == 0) w[15:9] = 7'b0110010;
      else if (sel == 1) w[15:9] = 7'b0110000;
      wv = 8'($urandom);
      if ($urandom % 4 == 0) wv = mem_val(exp_addr(w, b, e, ix));
      run_ins(w, wv, b, e, ix, 1'($urandom));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule